// File: doc/BRIEF.md
# Vendor Command Data Register for a JTAG Test Port

This block is the 8-bit data register that a test access port places between its serial input and output while the vendor-command instruction is loaded. An external programmer shifts a command byte in, least significant bit first. When the port passes through its data-update state, the block decodes the byte into device-control requests. It can hold the device in reset, enable or disable CPU fetches and loads from flash, start a chip erase, or force the configuration settings to be read again.

On every data-capture state the register is loaded with a live status byte. The programmer therefore reads the device condition while it shifts the next command in. The block also keeps track of which of two TAPs is active: the vendor TAP or a debug TAP. An instruction-update strobe carrying a select code switches between them, and a watchdog reset always returns the choice to the vendor TAP.

The TAP state machine, the flash array, the erase sequencer and the debug TAP lie outside this block. The TAP state machine supplies one-clock capture, shift and update strobes in the test-clock domain. The erase sequencer reports back through a busy input.

Top module: `vcmd_reg`

## Requirements
- R1: While `rst` is high and after it falls, `rst_req` is 0, `flash_en` equals the parameter `FLASH_EN_INIT` (default 1), `erase_start` and `cfg_reload` are 0, `dbg_sel` is 0 and `tdo` is 0.
- R2: On each clock with `sel_cmd` and `shift_dr` high, the register shifts right: `tdi` enters bit 7 and `tdo` always shows bit 0. A bit fed in therefore appears on `tdo` eight shift clocks later.
- R3: On a clock with `sel_cmd` and `capture_dr` high, the register loads the status byte. Bit 0 is `rst_req`, bit 1 is `erase_busy`, bit 2 is `flash_en` and bit 3 is `cfg_ready`. Bits 7 to 4 are 0.
- R4: An update (`sel_cmd` and `update_dr` high) holding byte 0xD1 sets `rst_req` from the next cycle on. Byte 0xD0 clears it. Otherwise it keeps its value.
- R5: An update holding 0xFE sets `flash_en`, and 0xFD clears it. Otherwise it keeps its value.
- R6: An update holding 0xFC while `erase_busy` is 0 raises `erase_start` for exactly the one cycle after the update clock. While `erase_busy` is 1, the command is ignored and `erase_start` stays 0.
- R7: An update holding 0xFF raises `cfg_reload` for exactly the one cycle after the update clock.
- R8: An update holding 0x00, or any byte not listed in R4 to R7, changes no output.
- R9: With `sel_cmd` low, the capture, shift and update strobes have no effect on the register or the outputs.
- R10: An `ir_load` pulse with `ir_code` 0x05 sets `dbg_sel` to 1, and one with 0x04 sets it to 0. Any other code leaves it unchanged.
- R11: A `wdt_rst` pulse sets `dbg_sel` to 0 on the next cycle, with priority over `ir_load`. It leaves `rst_req` and `flash_en` unchanged and does not cancel an erase start decoded in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset of the test logic |
| wdt_rst | input | 1 | Watchdog reset event, one clock |
| sel_cmd | input | 1 | Vendor-command instruction is active |
| capture_dr | input | 1 | Data-capture state strobe |
| shift_dr | input | 1 | Data-shift state strobe |
| update_dr | input | 1 | Data-update state strobe |
| tdi | input | 1 | Serial data in |
| ir_load | input | 1 | Instruction-update strobe |
| ir_code | input | IR_W | Instruction value presented with `ir_load` |
| erase_busy | input | 1 | Erase sequencer is running |
| cfg_ready | input | 1 | Configuration settings are valid |
| tdo | output | 1 | Serial data out, bit 0 of the register |
| rst_req | output | 1 | Sticky device-reset request |
| flash_en | output | 1 | Sticky flash-access enable |
| erase_start | output | 1 | One-cycle chip-erase start |
| cfg_reload | output | 1 | One-cycle configuration reload |
| dbg_sel | output | 1 | 1 when the debug TAP is selected |

## Verification
A wrong sticky control shows up in two places. It appears on `rst_req` or `flash_en` in the cycle after the faulty update. It also appears in the status byte, which reaches `tdo` in the cycle after the next capture. A wrong shift-register state shows on `tdo` within eight shift clocks, because every bit leaves the register by then. A mis-decoded pulse command appears or is missing in the single cycle after the update. A bad TAP choice is visible on `dbg_sel` one cycle after the strobe or watchdog event.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;
  localparam logic [7:0] OP_NOP     = 8'h00;
  localparam logic [7:0] OP_RST_ON  = 8'hD1;
  localparam logic [7:0] OP_RST_OFF = 8'hD0;
  localparam logic [7:0] OP_ERASE   = 8'hFC;
  localparam logic [7:0] OP_FL_ON   = 8'hFE;
  localparam logic [7:0] OP_FL_OFF  = 8'hFD;
  localparam logic [7:0] OP_CFG     = 8'hFF;

  localparam logic [4:0] IR_VENDOR  = 5'h04;
  localparam logic [4:0] IR_DEBUG   = 5'h05;

  localparam int STAT_W = 4;

  typedef struct packed {
    logic cfg_ready;
    logic flash_on;
    logic erase_busy;
    logic rst_on;
  } status_t;
endpackage

// File: rtl/vcmd_shreg.sv
module vcmd_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic         shf,
  input  logic         din,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= cap_val;
    else if (shf) q <= {din, q[W-1:1]};
  end
endmodule

// File: rtl/vcmd_decode.sv
module vcmd_decode
  import vcmd_pkg::*;
#(
  parameter int   W             = 8,
  parameter logic FLASH_EN_INIT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] cmd,
  input  logic         erase_busy,
  output logic         rst_req,
  output logic         flash_en,
  output logic         erase_start,
  output logic         cfg_reload
);
  logic hit_rst_on, hit_rst_off, hit_fl_on, hit_fl_off, hit_erase, hit_cfg;

  always_comb begin
    hit_rst_on  = upd && (cmd == W'(OP_RST_ON));
    hit_rst_off = upd && (cmd == W'(OP_RST_OFF));
    hit_fl_on   = upd && (cmd == W'(OP_FL_ON));
    hit_fl_off  = upd && (cmd == W'(OP_FL_OFF));
    hit_erase   = upd && (cmd == W'(OP_ERASE)) && !erase_busy;
    hit_cfg     = upd && (cmd == W'(OP_CFG));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req     <= 1'b0;
      flash_en    <= FLASH_EN_INIT;
      erase_start <= 1'b0;
      cfg_reload  <= 1'b0;
    end else begin
      if (hit_rst_on)       rst_req <= 1'b1;
      else if (hit_rst_off) rst_req <= 1'b0;
      if (hit_fl_on)        flash_en <= 1'b1;
      else if (hit_fl_off)  flash_en <= 1'b0;
      erase_start <= hit_erase;
      cfg_reload  <= hit_cfg;
    end
  end
endmodule

// File: rtl/vcmd_tapsel.sv
module vcmd_tapsel
  import vcmd_pkg::*;
#(
  parameter int IR_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wdt_rst,
  input  logic            ir_load,
  input  logic [IR_W-1:0] ir_code,
  output logic            dbg_sel
);
  always_ff @(posedge clk) begin
    if (rst || wdt_rst) dbg_sel <= 1'b0;
    else if (ir_load) begin
      if (ir_code == IR_W'(IR_DEBUG))       dbg_sel <= 1'b1;
      else if (ir_code == IR_W'(IR_VENDOR)) dbg_sel <= 1'b0;
    end
  end
endmodule

// File: rtl/vcmd_reg.sv
module vcmd_reg
  import vcmd_pkg::*;
#(
  parameter int   CMD_W         = 8,
  parameter int   IR_W          = 5,
  parameter logic FLASH_EN_INIT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wdt_rst,
  input  logic            sel_cmd,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  input  logic            ir_load,
  input  logic [IR_W-1:0] ir_code,
  input  logic            erase_busy,
  input  logic            cfg_ready,
  output logic            tdo,
  output logic            rst_req,
  output logic            flash_en,
  output logic            erase_start,
  output logic            cfg_reload,
  output logic            dbg_sel
);
  localparam int PAD_W = CMD_W - STAT_W;

  status_t          stat;
  logic [CMD_W-1:0] sr;
  logic [CMD_W-1:0] cap_val;

  always_comb begin
    stat.cfg_ready  = cfg_ready;
    stat.flash_on   = flash_en;
    stat.erase_busy = erase_busy;
    stat.rst_on     = rst_req;
    cap_val         = {{PAD_W{1'b0}}, stat};
  end

  vcmd_shreg #(.W(CMD_W)) u_sh (
    .clk(clk), .rst(rst),
    .cap(sel_cmd && capture_dr),
    .shf(sel_cmd && shift_dr),
    .din(tdi), .cap_val(cap_val), .q(sr)
  );

  assign tdo = sr[0];

  vcmd_decode #(.W(CMD_W), .FLASH_EN_INIT(FLASH_EN_INIT)) u_dec (
    .clk(clk), .rst(rst),
    .upd(sel_cmd && update_dr),
    .cmd(sr), .erase_busy(erase_busy),
    .rst_req(rst_req), .flash_en(flash_en),
    .erase_start(erase_start), .cfg_reload(cfg_reload)
  );

  vcmd_tapsel #(.IR_W(IR_W)) u_tap (
    .clk(clk), .rst(rst), .wdt_rst(wdt_rst),
    .ir_load(ir_load), .ir_code(ir_code), .dbg_sel(dbg_sel)
  );
endmodule

// File: rtl/vcmd_reg_chk.sv
module vcmd_reg_chk #(
  parameter int IR_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            wdt_rst,
  input logic            sel_cmd,
  input logic            capture_dr,
  input logic            shift_dr,
  input logic            update_dr,
  input logic            tdi,
  input logic            ir_load,
  input logic [IR_W-1:0] ir_code,
  input logic            erase_busy,
  input logic            cfg_ready,
  input logic            tdo,
  input logic            rst_req,
  input logic            flash_en,
  input logic            erase_start,
  input logic            cfg_reload,
  input logic            dbg_sel
);
  AST_STATUS_BIT0: assert property (@(posedge clk) disable iff (rst)
    (sel_cmd && capture_dr) |=> (tdo == $past(rst_req))); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(sel_cmd && update_dr) |=> ($stable(rst_req) && $stable(flash_en))); // R4
  AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start); // R6
  AST_ERASE_BUSY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (sel_cmd && update_dr && erase_busy) |=> !erase_start); // R6
  AST_RELOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cfg_reload |=> !cfg_reload); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({erase_start, cfg_reload})); // R8
  AST_NO_SEL_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !sel_cmd |=> (!erase_start && !cfg_reload)); // R9
  AST_WDT_VENDOR: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> !dbg_sel); // R11
  AST_DBG_SELECT: assert property (@(posedge clk) disable iff (rst)
    (ir_load && !wdt_rst && ir_code == IR_W'(5'h05)) |=> dbg_sel); // R10
endmodule

bind vcmd_reg vcmd_reg_chk #(.IR_W(IR_W)) u_chk (.*);

// File: tb/vcmd_reg_test.sv
module vcmd_reg_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wdt_rst = 0, sel_cmd = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic ir_load = 0;
  logic [4:0] ir_code = '0;
  logic erase_busy = 0, cfg_ready = 1;
  logic tdo, rst_req, flash_en, erase_start, cfg_reload, dbg_sel;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vcmd_reg uut (
    .clk(clk), .rst(rst), .wdt_rst(wdt_rst), .sel_cmd(sel_cmd),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .ir_load(ir_load), .ir_code(ir_code),
    .erase_busy(erase_busy), .cfg_ready(cfg_ready),
    .tdo(tdo), .rst_req(rst_req), .flash_en(flash_en),
    .erase_start(erase_start), .cfg_reload(cfg_reload), .dbg_sel(dbg_sel)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // capture, eight shifts, update; returns the byte seen on tdo
  task automatic scan(input logic [7:0] cmd, input logic s, input logic wdt_at_upd,
                      output logic [7:0] st);
    @(negedge clk); sel_cmd = s; capture_dr = 1;
    @(negedge clk); capture_dr = 0;
    for (int i = 0; i < 8; i++) begin
      st[i] = tdo; shift_dr = 1; tdi = cmd[i];
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1; wdt_rst = wdt_at_upd;
    @(negedge clk); update_dr = 0; wdt_rst = 0; sel_cmd = 0;
  endtask

  task automatic ir(input logic [4:0] c);
    @(negedge clk); ir_load = 1; ir_code = c;
    @(negedge clk); ir_load = 0;
  endtask

  // {cmd, busy, exp rst_req, exp flash_en, exp erase_start, exp cfg_reload}
  localparam logic [12:0] VEC [10] = '{
    {8'hD1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'hFD, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hFC, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'hFC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'hD0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hFE, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  initial begin
    logic [7:0] st;
    logic m_rst, m_fl;
    logic [15:0] pat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rst_req", {7'd0, rst_req}, 8'd0);
    check("R1 flash_en", {7'd0, flash_en}, 8'd1);
    check("R1 pulses", {6'd0, erase_start, cfg_reload}, 8'd0);
    check("R1 dbg_sel", {7'd0, dbg_sel}, 8'd0);
    check("R1 tdo", {7'd0, tdo}, 8'd0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1 after release", {5'd0, rst_req, flash_en, dbg_sel}, 8'b010);

    m_rst = 0; m_fl = 1;
    foreach (VEC[k]) begin
      logic [12:0] v;
      v = VEC[k];
      erase_busy = v[4];
      scan(v[12:5], 1'b1, 1'b0, st);
      // R3 status seen during this shift
      check("R3 status", st, {4'd0, cfg_ready, m_fl, v[4], m_rst});
      // R4 R5 R8 sticky controls, R6 R7 pulses
      check("R4 rst_req", {7'd0, rst_req}, {7'd0, v[3]});
      check("R5 flash_en", {7'd0, flash_en}, {7'd0, v[2]});
      check("R6 erase_start", {7'd0, erase_start}, {7'd0, v[1]});
      check("R7 cfg_reload", {7'd0, cfg_reload}, {7'd0, v[0]});
      @(negedge clk);
      check("R6 R7 pulse width", {6'd0, erase_start, cfg_reload}, 8'd0);
      m_rst = v[3]; m_fl = v[2];
    end
    erase_busy = 0;

    // R2 shift path: bits reappear eight clocks later
    pat = 16'hC3A5;
    @(negedge clk); sel_cmd = 1; shift_dr = 1;
    for (int i = 0; i < 16; i++) begin
      tdi = pat[i];
      @(negedge clk);
      if (i >= 7 && i < 15) check("R2 tdo delay", {7'd0, tdo}, {7'd0, pat[i-7]});
    end
    shift_dr = 0; sel_cmd = 0;

    // R9 strobes ignored without sel_cmd
    scan(8'hD1, 1'b0, 1'b0, st);
    check("R9 rst_req", {7'd0, rst_req}, 8'd0);
    check("R9 pulses", {6'd0, erase_start, cfg_reload}, 8'd0);

    // R10 TAP selection
    ir(5'h05);
    check("R10 debug", {7'd0, dbg_sel}, 8'd1);
    ir(5'h1F);
    check("R10 other code", {7'd0, dbg_sel}, 8'd1);
    ir(5'h04);
    check("R10 vendor", {7'd0, dbg_sel}, 8'd0);

    // R11 watchdog returns selection, keeps sticky controls
    scan(8'hD1, 1'b1, 1'b0, st);
    ir(5'h05);
    @(negedge clk); wdt_rst = 1; ir_load = 1; ir_code = 5'h05;
    @(negedge clk); wdt_rst = 0; ir_load = 0;
    check("R11 dbg_sel", {7'd0, dbg_sel}, 8'd0);
    check("R11 sticky kept", {6'd0, rst_req, flash_en}, 8'b11);
    scan(8'hFC, 1'b1, 1'b1, st);
    check("R11 erase kept", {7'd0, erase_start}, 8'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule